// File: doc/BRIEF.md
# Square-Wave Countdown Timer

This block is a 14-bit down-counting timer that advances on one-cycle tick pulses from an external timer input, already brought into the system clock domain. It produces a single or repeating square wave, or a single or repeating low pulse at terminal count. Software stages a count length and a two-bit waveform mode as two byte writes. A separate command input starts the timer, stops it at once, or stops it at the next terminal count.

The counter steps down by two on every tick and makes two passes per output period. The first pass covers the high half of a square wave. The second pass covers the low half. An odd length makes the high half one tick longer than the low half. Staged values take effect only through a launch command. If the timer is already running, the launch is deferred to the end of the current period.

The block reports three things: the timer output pin, a one-cycle terminal-count event for an external status flag, and the live count for readback. Bus decoding and clearing of the status flag belong to the surrounding logic.

Top module: `square_timer`

## Requirements
- R1: A low-byte write stores wr_data_i[7:0] as count bits 7:0. A high-byte write stores wr_data_i[5:0] as count bits 13:8 and wr_data_i[7:6] as the mode. The modes are: 00 one square wave, 01 repeating square wave, 10 one pulse, 11 repeating pulses. Staged bytes do not change a running timer.
- R2: Command 11 (launch) on an idle timer with a staged length of at least 2 starts the timer, and count_o equals the length on the next cycle. A staged length of 0 or 1 does not start the timer.
- R3: Each tick lowers the count by two. One period lasts exactly L ticks. The first half lasts ceil(L/2) ticks and the second half lasts floor(L/2) ticks.
- R4: In modes 00 and 01, tmr_out_o is high during the first half of the period and low during the second half.
- R5: In modes 10 and 11, tmr_out_o stays high except during the last tick interval of each period, when it is low.
- R6: tc_evt_o is high only in the clock cycle of the tick that ends a period.
- R7: Modes 01 and 11 restart automatically at terminal count. Modes 00 and 10 stop after one period. A stopped timer drives tmr_out_o high.
- R8: Command 01 (halt) stops a running timer at once. Further ticks then leave count_o unchanged and produce no terminal-count event.
- R9: Command 10 lets a running timer finish its current period and then stops it. On an idle timer it has no effect.
- R10: A launch on a running timer captures the staged length and mode at the time of the command. It applies them at the next terminal count, and the old period runs to its end first.
- R11: Reset stops the timer and drives tmr_out_o high. It keeps the count and the staged values, so a later launch restarts the timer from the staged length.
- R12: Command 00 has no effect on the count or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per timer input period |
| wr_lo_i | input | 1 | Write the low staging byte |
| wr_hi_i | input | 1 | Write the high staging byte (count high bits and mode) |
| wr_data_i | input | 8 | Staging byte data |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command: 00 nop, 01 halt, 10 halt at terminal count, 11 launch |
| tmr_out_o | output | 1 | Timer output waveform |
| tc_evt_o | output | 1 | Terminal-count event |
| count_o | output | 14 | Live count value |

## Verification
The assertions check the following on every cycle. The second-half count is always even. The timer starts only after a launch with a legal length. A halt clears the running state on the next cycle. A single-shot mode stops at its terminal count. A stopped timer holds its count and drives the output high. The square modes drive the output low during the second half. Byte writes land in the right fields. The bench scenarios are needed for everything that depends on a whole period: the exact high and low widths for odd and even lengths, the number of terminal-count events, the deferral of a launch to the end of the running period, and the count and staging values kept through a reset.

// File: rtl/sqtmr_pkg.sv
package sqtmr_pkg;
  typedef enum logic [1:0] {
    MODE_SQ_ONCE    = 2'b00,
    MODE_SQ_LOOP    = 2'b01,
    MODE_PULSE_ONCE = 2'b10,
    MODE_PULSE_LOOP = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    CMD_NOP        = 2'b00,
    CMD_HALT       = 2'b01,
    CMD_HALT_AT_TC = 2'b10,
    CMD_LAUNCH     = 2'b11
  } tmr_cmd_e;

  // bit 0 of the mode selects automatic restart
  function automatic logic mode_loops(input wave_mode_e m);
    return m[0];
  endfunction

  // bit 1 of the mode selects pulse shaping instead of square wave
  function automatic logic mode_pulse(input wave_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/tmr_stage_regs.sv
module tmr_stage_regs
  import sqtmr_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  stage_len,
  output wave_mode_e        stage_mode
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] len_q, len_n;
  wave_mode_e       mode_q, mode_n;

  // staging data carries no reset: its value survives a reset
  always_comb begin
    len_n  = len_q;
    mode_n = mode_q;
    if (wr_lo) len_n[BYTE_W-1:0] = wr_data;
    if (wr_hi) begin
      len_n[CNT_W-1:BYTE_W] = wr_data[HI_W-1:0];
      mode_n                = wave_mode_e'(wr_data[BYTE_W-1 -: 2]);
    end
  end

  always_ff @(posedge clk) begin
    len_q  <= len_n;
    mode_q <= mode_n;
  end

  assign stage_len  = len_q;
  assign stage_mode = mode_q;

  assert_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (stage_len[BYTE_W-1:0] == $past(wr_data)));

  assert_high_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (stage_mode == wave_mode_e'($past(wr_data[BYTE_W-1 -: 2]))));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import sqtmr_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  input  tmr_cmd_e         cmd,
  input  logic [CNT_W-1:0] stage_len,
  input  wave_mode_e       stage_mode,
  output logic             running,
  output logic             second_half,
  output logic [CNT_W-1:0] cnt,
  output wave_mode_e       act_mode,
  output logic             tc_evt
);
  localparam logic [CNT_W-1:0] STEP    = CNT_W'(2);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  // control state, reset
  logic run_q, run_n;
  logic half_q, half_n;
  logic pstart_q, pstart_n;
  logic pstop_q, pstop_n;
  // data state, not reset
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] alen_q, alen_n;
  logic [CNT_W-1:0] plen_q, plen_n;
  wave_mode_e       amode_q, amode_n;
  wave_mode_e       pmode_q, pmode_n;

  logic step_en, half_end, tc_now, len_ok;

  assign step_en  = run_q && tick;
  assign half_end = step_en && (cnt_q <= STEP);
  assign tc_now   = half_end && half_q;
  assign len_ok   = (stage_len >= MIN_LEN);

  always_comb begin
    run_n    = run_q;
    half_n   = half_q;
    pstart_n = pstart_q;
    pstop_n  = pstop_q;
    cnt_n    = cnt_q;
    alen_n   = alen_q;
    plen_n   = plen_q;
    amode_n  = amode_q;
    pmode_n  = pmode_q;

    // tick processing
    if (step_en) begin
      if (!half_end) begin
        cnt_n = cnt_q - STEP;
      end else if (!half_q) begin
        half_n = 1'b1;
        cnt_n  = {alen_q[CNT_W-1:1], 1'b0};
      end else if (pstart_q) begin
        alen_n   = plen_q;
        amode_n  = pmode_q;
        cnt_n    = plen_q;
        half_n   = 1'b0;
        pstart_n = 1'b0;
      end else if (pstop_q || !mode_loops(amode_q)) begin
        run_n   = 1'b0;
        half_n  = 1'b0;
        pstop_n = 1'b0;
      end else begin
        cnt_n  = alen_q;
        half_n = 1'b0;
      end
    end

    // command processing overrides the tick result where it conflicts
    if (cmd_valid) begin
      unique case (cmd)
        CMD_HALT: begin
          if (run_q) begin
            run_n    = 1'b0;
            half_n   = 1'b0;
            pstart_n = 1'b0;
            pstop_n  = 1'b0;
            cnt_n    = cnt_q;
            alen_n   = alen_q;
            amode_n  = amode_q;
          end
        end
        CMD_HALT_AT_TC: begin
          if (run_n) begin
            pstop_n  = 1'b1;
            pstart_n = 1'b0;
          end
        end
        CMD_LAUNCH: begin
          if (len_ok) begin
            if (!run_n) begin
              run_n    = 1'b1;
              half_n   = 1'b0;
              alen_n   = stage_len;
              amode_n  = stage_mode;
              cnt_n    = stage_len;
              pstart_n = 1'b0;
              pstop_n  = 1'b0;
            end else begin
              plen_n   = stage_len;
              pmode_n  = stage_mode;
              pstart_n = 1'b1;
              pstop_n  = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      half_q   <= 1'b0;
      pstart_q <= 1'b0;
      pstop_q  <= 1'b0;
    end else begin
      run_q    <= run_n;
      half_q   <= half_n;
      pstart_q <= pstart_n;
      pstop_q  <= pstop_n;
    end
  end

  always_ff @(posedge clk) begin
    cnt_q   <= cnt_n;
    alen_q  <= alen_n;
    plen_q  <= plen_n;
    amode_q <= amode_n;
    pmode_q <= pmode_n;
  end

  assign running     = run_q;
  assign second_half = half_q;
  assign cnt         = cnt_q;
  assign act_mode    = amode_q;
  assign tc_evt      = tc_now;

  assert_even_second_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && half_q) |-> !cnt_q[0]);

  assert_start_by_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(cmd_valid && cmd == CMD_LAUNCH));

  assert_legal_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (alen_q >= MIN_LEN));

  assert_halt_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_HALT) |=> !run_q);

  assert_single_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_now && !mode_loops(amode_q) && !pstart_q && !(cmd_valid && cmd == CMD_LAUNCH))
      |=> !run_q);

  assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(cmd_valid && cmd == CMD_LAUNCH)) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
  import sqtmr_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             second_half,
  input  logic [CNT_W-1:0] cnt,
  input  wave_mode_e       mode,
  output logic             wave
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2);

  logic final_step;
  assign final_step = second_half && (cnt <= LAST);

  always_comb begin
    if (!running)              wave = 1'b1;
    else if (mode_pulse(mode)) wave = !final_step;
    else                       wave = !second_half;
  end

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> wave);

  assert_square_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !mode[1] && second_half) |-> !wave);
endmodule

// File: rtl/square_timer.sv
module square_timer
  import sqtmr_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  output logic              tmr_out_o,
  output logic              tc_evt_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] stage_len;
  wave_mode_e       stage_mode;
  logic             running, second_half;
  logic [CNT_W-1:0] cnt;
  wave_mode_e       act_mode;

  tmr_stage_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo      (wr_lo_i),
    .wr_hi      (wr_hi_i),
    .wr_data    (wr_data_i),
    .stage_len  (stage_len),
    .stage_mode (stage_mode)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_i),
    .cmd_valid   (cmd_valid_i),
    .cmd         (tmr_cmd_e'(cmd_i)),
    .stage_len   (stage_len),
    .stage_mode  (stage_mode),
    .running     (running),
    .second_half (second_half),
    .cnt         (cnt),
    .act_mode    (act_mode),
    .tc_evt      (tc_evt_o)
  );

  tmr_wave_gen #(.CNT_W(CNT_W)) u_wave (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (running),
    .second_half (second_half),
    .cnt         (cnt),
    .mode        (act_mode),
    .wave        (tmr_out_o)
  );

  assign count_o = cnt;
endmodule

// File: tb/square_timer_tb_top.sv
module square_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic [13:0] len;
    logic [1:0]  mode;
    logic [7:0]  ticks;
    logic [7:0]  highs;
    logic [7:0]  tcs;
  } vec_t;

  // length, mode, ticks observed, expected high samples, expected tc events
  localparam vec_t VECS [NV] = '{
    '{14'd4, 2'b01, 8'd8,  8'd4,  8'd2},
    '{14'd5, 2'b01, 8'd10, 8'd6,  8'd2},
    '{14'd5, 2'b00, 8'd10, 8'd8,  8'd1},
    '{14'd3, 2'b11, 8'd6,  8'd4,  8'd2},
    '{14'd2, 2'b10, 8'd4,  8'd3,  8'd1},
    '{14'd7, 2'b01, 8'd14, 8'd8,  8'd2},
    '{14'd6, 2'b11, 8'd12, 8'd10, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, wr_lo_i, wr_hi_i, cmd_valid_i;
  logic [7:0]  wr_data_i;
  logic [1:0]  cmd_i;
  logic        tmr_out_o, tc_evt_o;
  logic [13:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  square_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_lo_i(wr_lo_i),
    .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i), .cmd_valid_i(cmd_valid_i),
    .cmd_i(cmd_i), .tmr_out_o(tmr_out_o), .tc_evt_o(tc_evt_o), .count_o(count_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [13:0] len, input logic [1:0] mode);
    @(negedge clk); wr_lo_i = 1'b1; wr_data_i = len[7:0];
    @(negedge clk); wr_lo_i = 1'b0; wr_hi_i = 1'b1; wr_data_i = {mode, len[13:8]};
    @(negedge clk); wr_hi_i = 1'b0;
  endtask

  task automatic send(input logic [1:0] c);
    @(negedge clk); cmd_valid_i = 1'b1; cmd_i = c;
    @(negedge clk); cmd_valid_i = 1'b0;
  endtask

  task automatic do_tick(output int o, output int t);
    @(negedge clk); tick_i = 1'b1;
    #1; o = int'(tmr_out_o); t = int'(tc_evt_o);
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic run_ticks(input int n, output int highs, output int tcs);
    int o, t;
    highs = 0; tcs = 0;
    for (int k = 0; k < n; k++) begin
      do_tick(o, t);
      highs += o; tcs += t;
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int h, t;
    rst_n = 1'b0; tick_i = 1'b0; wr_lo_i = 1'b0; wr_hi_i = 1'b0;
    cmd_valid_i = 1'b0; cmd_i = 2'b00; wr_data_i = 8'h00;
    repeat (3) @(negedge clk);
    chk("R11", "out in reset", int'(tmr_out_o), 1);
    chk("R6", "tc in reset", int'(tc_evt_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 across lengths and modes
    for (int i = 0; i < NV; i++) begin
      send(2'b01);
      load(VECS[i].len, VECS[i].mode);
      send(2'b11);
      chk("R2", "count after launch", int'(count_o), int'(VECS[i].len));
      chk("R4", "high at start", int'(tmr_out_o), 1);
      run_ticks(int'(VECS[i].ticks), h, t);
      chk("R3 R4 R5", "high samples", h, int'(VECS[i].highs));
      chk("R6 R7", "tc events", t, int'(VECS[i].tcs));
    end

    // R2: length 1 is refused
    send(2'b01);
    load(14'd1, 2'b01);
    send(2'b11);
    run_ticks(4, h, t);
    chk("R2", "len1 highs", h, 4);
    chk("R2", "len1 tc", t, 0);

    // R8: halt stops at once and freezes the count
    load(14'd10, 2'b01);
    send(2'b11);
    run_ticks(2, h, t);
    chk("R3", "count after 2 ticks", int'(count_o), 6);
    send(2'b01);
    run_ticks(3, h, t);
    chk("R8", "count frozen", int'(count_o), 6);
    chk("R8", "out high after halt", h, 3);
    chk("R8", "no tc after halt", t, 0);

    // R9: halt at terminal count
    send(2'b10);
    chk("R9", "idle halt-at-tc count", int'(count_o), 6);
    load(14'd4, 2'b01);
    send(2'b11);
    run_ticks(1, h, t);
    send(2'b10);
    run_ticks(7, h, t);
    chk("R9", "one tc then stop", t, 1);
    chk("R9", "highs after stop", h, 5);

    // R1 R10 R12: staged bytes ignored, launch deferred to tc
    load(14'd4, 2'b01);
    send(2'b11);
    run_ticks(1, h, t);
    chk("R3", "count after tick", int'(count_o), 2);
    load(14'd6, 2'b11);
    chk("R1", "staging ignored while running", int'(count_o), 2);
    send(2'b00);
    chk("R12", "nop keeps count", int'(count_o), 2);
    chk("R12", "nop keeps out", int'(tmr_out_o), 1);
    send(2'b11);
    chk("R10", "launch deferred", int'(count_o), 2);
    run_ticks(3, h, t);
    chk("R10", "old period tc", t, 1);
    chk("R10", "old square highs", h, 1);
    chk("R10", "new length applied", int'(count_o), 6);
    run_ticks(6, h, t);
    chk("R10", "new pulse highs", h, 5);
    chk("R10", "new tc count", t, 1);

    // R11: reset mid-run keeps count and staging
    send(2'b01);
    load(14'd10, 2'b01);
    send(2'b11);
    run_ticks(3, h, t);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "out high in reset", int'(tmr_out_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "count kept", int'(count_o), 4);
    run_ticks(3, h, t);
    chk("R11", "stopped after reset", int'(count_o), 4);
    chk("R11", "no tc after reset", t, 0);
    send(2'b11);
    chk("R11", "relaunch from staging", int'(count_o), 10);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule